// File: doc/BRIEF.md
# PLL Divider Candidate Enumerator

This block walks through every setting of a frequency synthesizer's reference divider, feedback divider and output post-divider that could produce a requested output frequency from a fixed reference clock. A single-cycle `start` pulse captures four kHz values: the target output frequency, the lower and upper VCO limits, and the reference frequency. The block first picks a starting post-divider and VCO target. It then steps the reference divider downward, works out the feedback divider for each step, and sends every legal setting as a packed 32-bit word over a valid/ready stream. When the walk is finished it sends a terminator word.

A downstream ranking stage takes the stream, scores each word against the target, and uses the terminator to know that no more words will arrive. The feedback divider comes from a sequential restoring divider, so producing each word takes several tens of cycles. The stream stays quiet while that division is running.

The controller is a single state machine with these states:
- `S_IDLE` waits for `start`.
- `S_SETUP` loads the starting VCO target and post-divider code, and marks the reference divider as unset.
- `S_STEP` moves to the next divider setting. It finishes the walk by going to `S_FINAL`.
- `S_DIV_GO` starts the division.
- `S_DIV_WAIT` waits until the quotient is ready. It then goes to `S_EMIT` if the feedback divider is legal, or back to `S_STEP` if it is not.
- `S_EMIT` holds a candidate until it is accepted, then returns to `S_STEP`.
- `S_FINAL` holds the terminator until it is accepted, then returns to `S_IDLE`.

A `start` pulse in any state sends the machine to `S_SETUP`.

Top module: `pll_cand_enum`

## Requirements
- R1: After reset, `cand_valid` is low and stays low until `start` is pulsed.
- R2: Each candidate word carries zero in bits 31:24. Bits 23:16 hold the reference divider m, bits 15:8 the feedback divider n, and bits 7:0 the post-divider byte p.
- R3: If the target is greater than floor(vco_max/2), the walk starts in bypass: the low bits of p are 0x40. The VCO target is min(target, vco_max).
- R4: Otherwise the walk starts with post-divider code 3 and VCO target = target×16. While the code is nonzero and the VCO target exceeds vco_max, the code drops by one and the VCO target halves. A result below vco_min is raised to vco_min.
- R5: For each post-divider setting, m takes the values 9, 8, … 0 in that order.
- R6: After m reaches 0, the next step works as follows. If bypass (p bit 6) is already set, the walk ends. Otherwise the code in p bits 1:0 drops by one; if that code is 0, p becomes bypass 0x40 instead. The VCO target then halves, and the walk ends if the halved value is below vco_min.
- R7: Each time a post-divider setting is (re)entered, p is masked with 0x43 and then ORed with a band code for the VCO target: 0x00 below 550000, 0x08 below 700000, 0x10 below 1000000, 0x18 below 1150000, and 0x20 otherwise.
- R8: n = floor((vco·(m+1) + ref) / (2·ref)) − 2. Steps with n < 3 or n > 122, including negative results, produce no word.
- R9: After the last candidate the block emits exactly one word 0x01FFFFFF. Once that word is accepted, `cand_valid` goes low.
- R10: While `cand_valid` is high and `cand_ready` is low, the word holds steady. `cand_valid` is never high while the divider is busy.
- R11: A `start` pulse abandons any walk in progress. The next accepted word is the first word of the new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures the inputs and starts a new walk |
| tgt_khz | input | FREQ_W | Requested output frequency, kHz |
| vco_min_khz | input | FREQ_W | Lowest allowed VCO frequency, kHz |
| vco_max_khz | input | FREQ_W | Highest allowed VCO frequency, kHz |
| ref_khz | input | FREQ_W | Reference clock frequency, kHz |
| cand_valid | output | 1 | Candidate or terminator word is present |
| cand_ready | input | 1 | Consumer accepts the word this cycle |
| cand_word | output | 32 | Packed candidate {8'h00, m, n, p} or 0x01FFFFFF |

## Verification
After a start pulse, the first word appears no sooner than 3 + DW cycles later, where DW is the divider width (37 by default). Each later word needs at least DW + 2 cycles after the previous handshake, and each rejected step adds the same amount. Because of this, the bench never assumes a fixed latency. It drives `cand_ready` on the falling edge and samples `cand_valid` and `cand_word` on that same falling edge. A word counts as consumed only when both are high, and it is compared in order against a list of expected words worked out arithmetically for that configuration. When ready is held low, the word seen on the following falling edge must be the same. One falling edge after the terminator is accepted, valid must be low.

// File: rtl/pll_enum_pkg.sv
package pll_enum_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_STEP,
        S_DIV_GO,
        S_DIV_WAIT,
        S_EMIT,
        S_FINAL
    } walk_state_e;

    localparam logic [31:0] END_WORD   = 32'h01FF_FFFF;
    localparam logic [7:0]  P_BYPASS   = 8'h40;
    localparam logic [7:0]  P_KEEPMASK = 8'h43;
    localparam logic [7:0]  M_UNSET    = 8'hFF;

endpackage

// File: rtl/pll_div_restoring.sv
module pll_div_restoring #(
    parameter int DW = 37
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] quotient
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] quo_r;
    logic [DW-1:0] rem_r;
    logic [DW-1:0] dsr_r;
    logic [CW-1:0] cnt_r;
    logic [DW:0]   shifted;
    logic [DW:0]   diff;
    logic          ge;

    always_comb begin
        shifted = {rem_r, quo_r[DW-1]};
        diff    = shifted - {1'b0, dsr_r};
        ge      = (shifted >= {1'b0, dsr_r});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_r <= '0;
            rem_r <= '0;
            dsr_r <= '0;
            cnt_r <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                quo_r <= dividend;
                rem_r <= '0;
                dsr_r <= divisor;
                cnt_r <= CW'(DW);
                busy  <= 1'b1;
            end else if (busy) begin
                quo_r <= {quo_r[DW-2:0], ge};
                rem_r <= ge ? diff[DW-1:0] : shifted[DW-1:0];
                cnt_r <= cnt_r - CW'(1);
                if (cnt_r == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_r;

    // R10: the finish pulse never overlaps an active division
    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: a running division always has bits left to produce
    a_r10_busy_has_count: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_r != '0));

endmodule

// File: rtl/pll_walk_init.sv
module pll_walk_init #(
    parameter int FREQ_W = 32
) (
    input  logic [FREQ_W-1:0] tgt,
    input  logic [FREQ_W-1:0] vmin,
    input  logic [FREQ_W-1:0] vmax,
    output logic [7:0]        p_init,
    output logic [FREQ_W-1:0] vco_init
);
    import pll_enum_pkg::*;

    localparam int WW = FREQ_W + 4;

    logic [WW-1:0] wide_vco;
    logic [1:0]    code;

    always_comb begin
        wide_vco = '0;
        code     = 2'd3;
        p_init   = '0;
        vco_init = '0;
        if (tgt > (vmax >> 1)) begin
            p_init   = P_BYPASS;
            vco_init = (tgt > vmax) ? vmax : tgt;
        end else begin
            wide_vco = WW'(tgt) << 4;
            for (int i = 0; i < 3; i++) begin
                if ((code != 2'd0) && (wide_vco > WW'(vmax))) begin
                    code     = code - 2'd1;
                    wide_vco = wide_vco >> 1;
                end
            end
            if (wide_vco < WW'(vmin)) begin
                wide_vco = WW'(vmin);
            end
            p_init   = {6'd0, code};
            vco_init = wide_vco[FREQ_W-1:0];
        end
    end

endmodule

// File: rtl/pll_band_enc.sv
module pll_band_enc #(
    parameter int FREQ_W   = 32,
    parameter int BAND_T0  = 550000,
    parameter int BAND_T1  = 700000,
    parameter int BAND_T2  = 1000000,
    parameter int BAND_T3  = 1150000
) (
    input  logic [FREQ_W-1:0] vco,
    output logic [7:0]        band_bits
);
    localparam int NB = 4;
    localparam logic [FREQ_W-1:0] LIMITS [NB] = '{
        FREQ_W'(BAND_T0), FREQ_W'(BAND_T1), FREQ_W'(BAND_T2), FREQ_W'(BAND_T3)
    };

    logic [2:0] level;

    always_comb begin
        level = 3'(NB);
        for (int i = NB - 1; i >= 0; i--) begin
            if (vco < LIMITS[i]) begin
                level = 3'(i);
            end
        end
        band_bits = {2'b00, level, 3'b000};
    end

endmodule

// File: rtl/pll_cand_enum.sv
module pll_cand_enum #(
    parameter int FREQ_W  = 32,
    parameter int M_START = 9,
    parameter int N_MIN   = 3,
    parameter int N_MAX   = 122
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] tgt_khz,
    input  logic [FREQ_W-1:0] vco_min_khz,
    input  logic [FREQ_W-1:0] vco_max_khz,
    input  logic [FREQ_W-1:0] ref_khz,
    output logic              cand_valid,
    input  logic              cand_ready,
    output logic [31:0]       cand_word
);
    import pll_enum_pkg::*;

    localparam int DW = FREQ_W + $clog2(M_START + 2) + 1;
    localparam logic [DW-1:0] Q_LO = DW'(N_MIN + 2);
    localparam logic [DW-1:0] Q_HI = DW'(N_MAX + 2);

    walk_state_e state_r, state_nx;

    logic [FREQ_W-1:0] tgt_r, vmin_r, vmax_r, ref_r;
    logic [FREQ_W-1:0] vco_r;
    logic [7:0]        p_r, m_r, n_r;

    logic [7:0]        init_p;
    logic [FREQ_W-1:0] init_vco;

    logic              at_wrap, step_end;
    logic [7:0]        adv_p, step_p, next_p, band_bits;
    logic [FREQ_W-1:0] halved, step_vco;

    logic              div_go, div_busy, div_done;
    logic [DW-1:0]     div_quo, div_num, div_den;
    logic              n_ok;

    pll_walk_init #(.FREQ_W(FREQ_W)) init_i (
        .tgt      (tgt_r),
        .vmin     (vmin_r),
        .vmax     (vmax_r),
        .p_init   (init_p),
        .vco_init (init_vco)
    );

    pll_band_enc #(.FREQ_W(FREQ_W)) band_i (
        .vco       (step_vco),
        .band_bits (band_bits)
    );

    // Step arithmetic: next post-divider setting and VCO target
    always_comb begin
        at_wrap  = (m_r == 8'd0) || (m_r == M_UNSET);
        halved   = vco_r >> 1;
        adv_p    = (p_r[1:0] != 2'b00) ? (p_r - 8'd1) : P_BYPASS;
        step_end = (m_r == 8'd0) && (p_r[6] || (halved < vmin_r));
        step_vco = (m_r == 8'd0) ? halved : vco_r;
        step_p   = (m_r == 8'd0) ? adv_p : p_r;
        next_p   = (step_p & P_KEEPMASK) | band_bits;
    end

    // Feedback divider operands
    always_comb begin
        div_num = (DW'(vco_r) * (DW'(m_r) + DW'(1))) + DW'(ref_r);
        div_den = DW'(ref_r) << 1;
        n_ok    = (div_quo >= Q_LO) && (div_quo <= Q_HI);
        div_go  = (state_r == S_DIV_GO);
    end

    pll_div_restoring #(.DW(DW)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_num),
        .divisor  (div_den),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_quo)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r <= S_IDLE;
        end else begin
            state_r <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state_r;
        if (start) begin
            state_nx = S_SETUP;
        end else begin
            unique case (state_r)
                S_IDLE:     state_nx = S_IDLE;
                S_SETUP:    state_nx = S_STEP;
                S_STEP:     state_nx = (at_wrap && step_end) ? S_FINAL : S_DIV_GO;
                S_DIV_GO:   state_nx = S_DIV_WAIT;
                S_DIV_WAIT: if (div_done) state_nx = n_ok ? S_EMIT : S_STEP;
                S_EMIT:     if (cand_ready) state_nx = S_STEP;
                S_FINAL:    if (cand_ready) state_nx = S_IDLE;
                default:    state_nx = S_IDLE;
            endcase
        end
    end

    // Walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_r  <= '0;
            vmin_r <= '0;
            vmax_r <= '0;
            ref_r  <= '0;
            vco_r  <= '0;
            p_r    <= '0;
            m_r    <= M_UNSET;
            n_r    <= '0;
        end else if (start) begin
            tgt_r  <= tgt_khz;
            vmin_r <= vco_min_khz;
            vmax_r <= vco_max_khz;
            ref_r  <= ref_khz;
        end else begin
            unique case (state_r)
                S_SETUP: begin
                    vco_r <= init_vco;
                    p_r   <= init_p;
                    m_r   <= M_UNSET;
                end
                S_STEP: begin
                    if (!at_wrap) begin
                        m_r <= m_r - 8'd1;
                    end else if (!step_end) begin
                        vco_r <= step_vco;
                        p_r   <= next_p;
                        m_r   <= 8'(M_START);
                    end
                end
                S_DIV_WAIT: begin
                    if (div_done) begin
                        n_r <= div_quo[7:0] - 8'd2;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        cand_valid = (state_r == S_EMIT) || (state_r == S_FINAL);
        cand_word  = (state_r == S_FINAL) ? END_WORD : {8'h00, m_r, n_r, p_r};
    end

    // R10: no word is offered while a division is in flight
    a_r10_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> !cand_valid);

    // R10: a stalled word is held unchanged
    a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n || start)
        (cand_valid && !cand_ready) |=> (cand_valid && $stable(cand_word)));

    // R2: candidate top byte is zero
    a_r2_top_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_word != END_WORD) |-> (cand_word[31:24] == 8'h00));

    // R5: reference divider never exceeds its starting value
    a_r5_mref_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_word != END_WORD) |-> (cand_word[23:16] <= 8'(M_START)));

    // R8: emitted feedback divider is inside the legal window
    a_r8_n_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_word != END_WORD) |->
        ((cand_word[15:8] >= 8'(N_MIN)) && (cand_word[15:8] <= 8'(N_MAX))));

    // R7: post-divider byte holds only kept bits plus a legal band code
    a_r7_band_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_word != END_WORD) |->
        (((cand_word[7:0] & 8'h84) == 8'h00) && (cand_word[5:3] <= 3'd4)));

    // R9: accepted terminator leaves the stream idle
    a_r9_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r == S_FINAL && cand_ready && !start) |=> !cand_valid);

endmodule

// File: tb/pll_cand_enum_tb_top.sv
module pll_cand_enum_tb_top;

    localparam int unsigned END_W = 32'h01FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] tgt_khz = '0;
    logic [31:0] vco_min_khz = '0;
    logic [31:0] vco_max_khz = '0;
    logic [31:0] ref_khz = '0;
    logic        cand_valid;
    logic        cand_ready = 1'b0;
    logic [31:0] cand_word;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    pll_cand_enum dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .tgt_khz     (tgt_khz),
        .vco_min_khz (vco_min_khz),
        .vco_max_khz (vco_max_khz),
        .ref_khz     (ref_khz),
        .cand_valid  (cand_valid),
        .cand_ready  (cand_ready),
        .cand_word   (cand_word)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic longint band_of(input longint v);
        if (v < 550000)       return 'h00;
        else if (v < 700000)  return 'h08;
        else if (v < 1000000) return 'h10;
        else if (v < 1150000) return 'h18;
        else                  return 'h20;
    endfunction

    // Arithmetic model of the candidate sequence
    task automatic build_exp(input longint f, input longint vmn, input longint vmx,
                             input longint rf, ref int unsigned q[$]);
        longint p, vco, m, quo;
        q.delete();
        if (f > (vmx >> 1)) begin
            vco = (f > vmx) ? vmx : f;
            p   = 'h40;
        end else begin
            p   = 3;
            vco = f << 4;
            while (p != 0 && vco > vmx) begin
                p--;
                vco = vco >> 1;
            end
            if (vco < vmn) vco = vmn;
        end
        m = 'hFF;
        forever begin
            if (m == 0 || m == 'hFF) begin
                if (m == 0) begin
                    if ((p & 'h40) != 0) break;
                    p   = ((p & 3) != 0) ? p - 1 : 'h40;
                    vco = vco >> 1;
                    if (vco < vmn) break;
                end
                p = (p & 'h43) | band_of(vco);
                m = 9;
            end else begin
                m--;
            end
            quo = (vco * (m + 1) + rf) / (2 * rf);
            if (quo >= 5 && quo <= 124)
                q.push_back(int'((m << 16) | ((quo - 2) << 8) | p));
        end
        q.push_back(END_W);
    endtask

    task automatic pulse_start(input int unsigned f, input int unsigned vmn,
                               input int unsigned vmx, input int unsigned rf);
        @(negedge clk);
        cand_ready  = 1'b0;
        tgt_khz     = f;
        vco_min_khz = vmn;
        vco_max_khz = vmx;
        ref_khz     = rf;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Consume up to 'limit' words and compare them in order
    task automatic collect(ref int unsigned exp[$], input int limit, input bit stall,
                           input bit bypass_cfg, input bit aborted);
        int          idx = 0;
        bit          holding = 0;
        int unsigned held = 0;
        bit          rdy;
        string       tag;
        while (idx < limit) begin
            @(negedge clk);
            cyc++;
            rdy = stall ? ((cyc % 4) != 1) : 1'b1;
            if (holding) begin
                check(cand_valid && cand_word == held, "R10 held word", cand_word, held);
                holding = 0;
            end
            cand_ready = rdy;
            if (cand_valid) begin
                if (rdy) begin
                    if (aborted && idx == 0)            tag = "R11 restart first word";
                    else if (exp[idx] == END_W)         tag = "R9 end word";
                    else if (idx == 0 && bypass_cfg)    tag = "R3 bypass first word";
                    else if (idx == 0)                  tag = "R4 divided first word";
                    else                                tag = "R2/R5/R6/R7/R8 candidate";
                    check(cand_word == exp[idx], tag, cand_word, exp[idx]);
                    idx++;
                end else begin
                    holding = 1;
                    held    = cand_word;
                end
            end
        end
        @(negedge clk);
        cand_ready = 1'b0;
    endtask

    task automatic run_full(input int unsigned f, input int unsigned vmn,
                            input int unsigned vmx, input int unsigned rf, input bit stall);
        int unsigned exp[$];
        build_exp(f, vmn, vmx, rf, exp);
        pulse_start(f, vmn, vmx, rf);
        collect(exp, exp.size(), stall, (f > (vmx >> 1)), 1'b0);
        check(!cand_valid, "R9 idle after end", cand_valid, 0);
    endtask

    initial begin
        int unsigned expa[$];
        int unsigned expb[$];
        repeat (4) @(negedge clk);
        check(!cand_valid, "R1 reset valid low", cand_valid, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(!cand_valid, "R1 idle before start", cand_valid, 0);

        // Sweep of targets across raised-minimum, divided, bypass and clamped cases
        for (int k = 0; k < 24; k++) begin
            run_full(4000 + k * 61000, 256000, 1300000, 27000, (k % 2) == 1);
        end
        // Other reference and narrower VCO window
        for (int k = 0; k < 4; k++) begin
            run_full(30000 + k * 130000, 200000, 800000, 14318, k[0]);
        end

        // R11: abandon a walk after a few words, restart with another target
        build_exp(100000, 256000, 1300000, 27000, expa);
        build_exp(900000, 256000, 1300000, 27000, expb);
        pulse_start(100000, 256000, 1300000, 27000);
        collect(expa, 3, 1'b0, 1'b0, 1'b0);
        pulse_start(900000, 256000, 1300000, 27000);
        collect(expb, expb.size(), 1'b1, 1'b1, 1'b1);
        check(!cand_valid, "R11 idle after restarted walk", cand_valid, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule